// File: doc/BRIEF.md
# Grouped Two-Stage Interrupt Expander

This block gathers a wide set of interrupt request lines, arranged as groups of equal size, and reduces them to one request line per group at a CPU-facing stage. Every source owns a flag bit, latched on a rising edge of its request, and an enable bit. Each group holds a single acknowledge bit that closes the group after it has handed a request to the CPU stage, until software reopens it. The CPU stage holds one flag and one enable per group, plus one global mask bit that silences the CPU request line.

When the CPU takes an interrupt, the block names the winning group and source as a vector in the same cycle. At that clock edge it clears the matching CPU-stage flag and the matching source flag. All flags, enables, acknowledge bits and the mask can be read and written through a small word-addressed register port. A source flag written to 1 by software acts as a software interrupt.

Top module: `grp_irq_expander`

Register address: bits [5:4] select a bank and bits [3:0] select the group, where group 1 is index 0. Bank 0 holds the source flags, bank 1 the source enables and bank 2 the acknowledge bit, which reads in bit 0 and clears when bit 0 is written as 1. Bank 3 holds the CPU stage: index 0 is the CPU flags, index 1 the CPU enables and index 2 the global mask in bit 0. In the CPU flag and enable words, bit g-1 stands for group g. In a group word, bit s-1 stands for source s. Request input bit (g-1)*8+(s-1) belongs to group g, source s.

## Requirements
- R1: A rising edge on a request input sets that source's flag at the next clock edge, whether or not the source is enabled. A request held high does not set the flag again once it has been cleared.
- R2: When a group has a flag that is also enabled and its acknowledge bit is clear, the group sets its CPU-stage flag and its own acknowledge bit. With the CPU enable set and the mask clear, cpu_irq_o goes high two clock edges after the edge on which the request input was sampled high.
- R3: While a group's acknowledge bit is set, the group forwards nothing more to the CPU stage. A write of 1 in bit 0 to the acknowledge register clears it, and a pending enabled flag then forwards at the following edge.
- R4: cpu_irq_o is high exactly when some CPU flag has its CPU enable set and the global mask is 0.
- R5: Among the CPU requests that are pending and enabled, the lowest group number wins. Within the winning group, the lowest-numbered source that is flagged and enabled wins.
- R6: vec_valid_o is high in any cycle where cpu_take_i and cpu_irq_o are both high. In that cycle vec_grp_o gives the group number 1..12 and vec_src_o gives the source index 0..7, meaning sources 1..8. At that edge the winner's CPU flag and source flag clear.
- R7: A software write to a group flag register replaces the group's flags, so a written 1 acts as a software interrupt. A rising request on the same bit in the same cycle wins over a written 0.
- R8: Enable, CPU enable and mask registers read back what was written, limited to the implemented width: 8 bits per group, 12 CPU bits and 1 mask bit.
- R9: After reset all flags, enables, acknowledge bits, CPU flags, CPU enables and the mask are 0, and cpu_irq_o and vec_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 96 | Request inputs, 8 per group |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register address: bank in [5:4], group index in [3:0] |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data, combinational from the address |
| cpu_take_i | input | 1 | CPU takes the pending interrupt |
| cpu_irq_o | output | 1 | Interrupt request to the CPU |
| vec_valid_o | output | 1 | Vector valid, a strobe for one take |
| vec_grp_o | output | 4 | Winning group number, 1..12 |
| vec_src_o | output | 3 | Winning source index, 0..7 |

## Verification
A source flag becomes visible one edge after its request input is sampled high. The CPU-stage flag, and with it cpu_irq_o, follows one edge later, and the bench checks that cpu_irq_o is still low at the first of those points. Register writes take effect at the edge inside the write cycle. The vector outputs are combinational during the take cycle and are sampled shortly after the falling edge on which cpu_take_i rises. The clearing caused by a take is read back only after the next rising edge. All inputs change and all outputs are sampled around falling edges, so every check falls in a fixed cycle counted from its stimulus.

// File: rtl/ie_pkg.sv
package ie_pkg;
  localparam int unsigned DEF_NG = 12;
  localparam int unsigned DEF_NS = 8;
  localparam int unsigned DEF_DW = 16;

  typedef enum logic [1:0] {
    BANK_FLAG = 2'd0,
    BANK_EN   = 2'd1,
    BANK_ACK  = 2'd2,
    BANK_CPU  = 2'd3
  } ie_bank_e;

  localparam logic [1:0] CPU_IDX_IFR = 2'd0;
  localparam logic [1:0] CPU_IDX_IER = 2'd1;
  localparam logic [1:0] CPU_IDX_MSK = 2'd2;
endpackage

// File: rtl/ie_prio_pick.sv
module ie_prio_pick #(
  parameter int unsigned N  = 8,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/ie_group.sv
module ie_group #(
  parameter int unsigned NS = 8,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NS-1:0] src_i,
  input  logic          flag_wr_i,
  input  logic          en_wr_i,
  input  logic          ack_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [NS-1:0] fetch_clr_i,
  output logic [NS-1:0] flag_o,
  output logic [NS-1:0] en_o,
  output logic          ack_o,
  output logic          fwd_o
);
  logic [NS-1:0] src_q, flag_q, en_q, rise, flag_d;
  logic          ack_q, ack_d;

  assign rise = src_i & ~src_q;

  // hardware rise is OR-ed last so it beats a software or fetch clear
  always_comb begin
    flag_d = flag_wr_i ? wdata_i[NS-1:0] : flag_q;
    flag_d = (flag_d & ~fetch_clr_i) | rise;
  end

  assign fwd_o = (|(flag_q & en_q)) & ~ack_q;

  always_comb begin
    ack_d = ack_q;
    if (fwd_o) ack_d = 1'b1;
    else if (ack_wr_i && wdata_i[0]) ack_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      flag_q <= '0;
      en_q   <= '0;
      ack_q  <= 1'b0;
    end else begin
      src_q  <= src_i;
      flag_q <= flag_d;
      ack_q  <= ack_d;
      if (en_wr_i) en_q <= wdata_i[NS-1:0];
    end
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
  assign ack_o  = ack_q;

  AST_FWD_SETS_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_o |=> ack_o); // R2
  AST_ACK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !(ack_wr_i && wdata_i[0])) |=> ack_o); // R3

  for (genvar k = 0; k < NS; k++) begin : g_chk
    AST_RISE_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(src_i[k]) |=> flag_o[k]); // R1
  end
endmodule

// File: rtl/ie_cpu_stage.sv
module ie_cpu_stage #(
  parameter int unsigned NG = 12,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NG-1:0] set_i,
  input  logic [NG-1:0] clr_i,
  input  logic          ifr_wr_i,
  input  logic          ier_wr_i,
  input  logic          msk_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [NG-1:0] ifr_o,
  output logic [NG-1:0] ier_o,
  output logic          msk_o,
  output logic          irq_o
);
  logic [NG-1:0] ifr_q, ier_q, ifr_d;
  logic          msk_q;

  always_comb begin
    ifr_d = ifr_wr_i ? wdata_i[NG-1:0] : ifr_q;
    ifr_d = (ifr_d & ~clr_i) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ifr_q <= '0;
      ier_q <= '0;
      msk_q <= 1'b0;
    end else begin
      ifr_q <= ifr_d;
      if (ier_wr_i) ier_q <= wdata_i[NG-1:0];
      if (msk_wr_i) msk_q <= wdata_i[0];
    end
  end

  assign ifr_o = ifr_q;
  assign ier_o = ier_q;
  assign msk_o = msk_q;
  assign irq_o = (|(ifr_q & ier_q)) & ~msk_q;

  AST_TAKE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i != '0) && (set_i == '0) && !ifr_wr_i) |=> ((ifr_o & $past(clr_i)) == '0)); // R6
  AST_MASK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msk_o && !msk_wr_i) |=> !irq_o); // R4
endmodule

// File: rtl/grp_irq_expander.sv
module grp_irq_expander
  import ie_pkg::*;
#(
  parameter int unsigned NG = DEF_NG,
  parameter int unsigned NS = DEF_NS,
  parameter int unsigned DW = DEF_DW,
  localparam int unsigned IDX_W = $clog2(NG),
  localparam int unsigned AW    = IDX_W + 2,
  localparam int unsigned GW    = $clog2(NG + 1),
  localparam int unsigned SW    = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NG*NS-1:0] irq_i,
  input  logic             reg_wr_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  input  logic             cpu_take_i,
  output logic             cpu_irq_o,
  output logic             vec_valid_o,
  output logic [GW-1:0]    vec_grp_o,
  output logic [SW-1:0]    vec_src_o
);
  ie_bank_e             bank;
  logic [IDX_W-1:0]     gsel;
  logic                 gsel_ok;
  logic [NG-1:0][NS-1:0] flag_arr, en_arr, clr_arr;
  logic [NG-1:0]        ack_vec, grp_fwd, cpu_ifr, cpu_ier, cpu_clr;
  logic                 cpu_msk, take;
  logic [IDX_W-1:0]     win_g;
  logic                 win_any;
  logic [NS-1:0]        pend_src;
  logic [SW-1:0]        src_idx;
  logic                 src_any;

  assign bank    = ie_bank_e'(reg_addr_i[AW-1 -: 2]);
  assign gsel    = reg_addr_i[IDX_W-1:0];
  assign gsel_ok = ({1'b0, gsel} < (IDX_W+1)'(NG));

  ie_prio_pick #(.N(NG)) u_grp_pick (
    .req_i (cpu_ifr & cpu_ier),
    .idx_o (win_g),
    .any_o (win_any)
  );

  assign pend_src = flag_arr[win_g] & en_arr[win_g];

  ie_prio_pick #(.N(NS)) u_src_pick (
    .req_i (pend_src),
    .idx_o (src_idx),
    .any_o (src_any)
  );

  assign take = cpu_take_i & cpu_irq_o;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic sel;
    assign sel = gsel_ok && (gsel == IDX_W'(g)) && reg_wr_i;
    assign clr_arr[g] = (take && src_any && (win_g == IDX_W'(g)))
                        ? (NS'(1) << src_idx) : '0;

    ie_group #(.NS(NS), .DW(DW)) u_group (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .src_i       (irq_i[g*NS +: NS]),
      .flag_wr_i   (sel && (bank == BANK_FLAG)),
      .en_wr_i     (sel && (bank == BANK_EN)),
      .ack_wr_i    (sel && (bank == BANK_ACK)),
      .wdata_i     (reg_wdata_i),
      .fetch_clr_i (clr_arr[g]),
      .flag_o      (flag_arr[g]),
      .en_o        (en_arr[g]),
      .ack_o       (ack_vec[g]),
      .fwd_o       (grp_fwd[g])
    );
  end

  assign cpu_clr = take ? (NG'(1) << win_g) : '0;

  logic cpu_wr;
  assign cpu_wr = reg_wr_i && (bank == BANK_CPU);

  ie_cpu_stage #(.NG(NG), .DW(DW)) u_cpu (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (grp_fwd),
    .clr_i    (cpu_clr),
    .ifr_wr_i (cpu_wr && (reg_addr_i[1:0] == CPU_IDX_IFR)),
    .ier_wr_i (cpu_wr && (reg_addr_i[1:0] == CPU_IDX_IER)),
    .msk_wr_i (cpu_wr && (reg_addr_i[1:0] == CPU_IDX_MSK)),
    .wdata_i  (reg_wdata_i),
    .ifr_o    (cpu_ifr),
    .ier_o    (cpu_ier),
    .msk_o    (cpu_msk),
    .irq_o    (cpu_irq_o)
  );

  assign vec_valid_o = take;
  assign vec_grp_o   = GW'(win_g) + GW'(1);
  assign vec_src_o   = src_idx;

  always_comb begin
    reg_rdata_o = '0;
    unique case (bank)
      BANK_FLAG: if (gsel_ok) reg_rdata_o[NS-1:0] = flag_arr[gsel];
      BANK_EN:   if (gsel_ok) reg_rdata_o[NS-1:0] = en_arr[gsel];
      BANK_ACK:  if (gsel_ok) reg_rdata_o[0]      = ack_vec[gsel];
      BANK_CPU: begin
        if (reg_addr_i[1:0] == CPU_IDX_IFR) reg_rdata_o[NG-1:0] = cpu_ifr;
        else if (reg_addr_i[1:0] == CPU_IDX_IER) reg_rdata_o[NG-1:0] = cpu_ier;
        else if (reg_addr_i[1:0] == CPU_IDX_MSK) reg_rdata_o[0] = cpu_msk;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  AST_FWD_REACHES_CPU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_fwd != '0) |=> ((cpu_ifr & $past(grp_fwd)) == $past(grp_fwd))); // R2
  AST_VEC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> ((vec_grp_o != '0) && (int'(vec_grp_o) <= NG) && win_any)); // R6
  AST_CLR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cpu_clr)); // R5
endmodule

// File: tb/grp_irq_expander_tb_top.sv
`timescale 1ns/1ps
module grp_irq_expander_tb_top;
  localparam int NG = 12;
  localparam int NS = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [95:0] irq = '0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        take = 1'b0;
  logic        cpu_irq, vvalid;
  logic [3:0]  vgrp;
  logic [2:0]  vsrc;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  grp_irq_expander dut_i (
    .clk_i (clk), .rst_ni (rst_n), .irq_i (irq),
    .reg_wr_i (we), .reg_addr_i (addr), .reg_wdata_i (wdata), .reg_rdata_o (rdata),
    .cpu_take_i (take), .cpu_irq_o (cpu_irq),
    .vec_valid_o (vvalid), .vec_grp_o (vgrp), .vec_src_o (vsrc)
  );

  function automatic logic [5:0] ra(input int bank, input int idx);
    return {2'(bank), 4'(idx)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse(input logic [95:0] m);
    @(negedge clk); irq = irq | m;
    @(negedge clk); irq = irq & ~m;
  endtask

  task automatic do_take(output logic v, output logic [3:0] g, output logic [2:0] s);
    @(negedge clk); take = 1'b1; #1 v = vvalid; g = vgrp; s = vsrc;
    @(negedge clk); take = 1'b0;
  endtask

  task automatic cleanup();
    wr(ra(3, 2), 16'h0);
    for (int g = 0; g < NG; g++) begin
      wr(ra(1, g), 16'h0);
      wr(ra(0, g), 16'h0);
      wr(ra(2, g), 16'h1);
    end
    wr(ra(3, 0), 16'h0);
    wr(ra(3, 1), 16'h0);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R9 cpu_irq", 32'(cpu_irq), 0);
    chk("R9 vec_valid", 32'(vvalid), 0);
    rd(ra(0, 4), d); chk("R9 flag", 32'(d), 0);
    rd(ra(1, 11), d); chk("R9 enable", 32'(d), 0);
    rd(ra(2, 0), d); chk("R9 ack", 32'(d), 0);
    rd(ra(3, 1), d); chk("R9 cpu enable", 32'(d), 0);
  endtask

  task automatic t_regs();
    logic [15:0] d;
    wr(ra(1, 7), 16'h01FF);
    rd(ra(1, 7), d); chk("R8 enable width", 32'(d), 32'h00FF);
    wr(ra(3, 1), 16'hFABC);
    rd(ra(3, 1), d); chk("R8 cpu enable width", 32'(d), 32'h0ABC);
    wr(ra(3, 2), 16'hFFFF);
    rd(ra(3, 2), d); chk("R8 mask width", 32'(d), 32'h1);
    cleanup();
  endtask

  task automatic t_latch();
    logic [15:0] d;
    @(negedge clk); irq[0] = 1'b1;
    tick(1);
    rd(ra(0, 0), d); chk("R1 latch disabled", 32'(d), 32'h01);
    chk("R1 no irq when disabled", 32'(cpu_irq), 0);
    wr(ra(0, 0), 16'h0);
    tick(2);
    rd(ra(0, 0), d); chk("R1 held level no relatch", 32'(d), 0);
    @(negedge clk); irq[0] = 1'b0;
    cleanup();
  endtask

  task automatic t_forward();
    logic [15:0] d; logic v; logic [3:0] g; logic [2:0] s;
    wr(ra(1, 2), 16'h10);
    wr(ra(3, 1), 16'h004);
    pulse(96'(1) << (2*8+4));
    chk("R2 not yet at cpu", 32'(cpu_irq), 0);
    tick(1);
    chk("R2 cpu irq after two edges", 32'(cpu_irq), 1);
    rd(ra(2, 2), d); chk("R2 ack set", 32'(d), 1);
    do_take(v, g, s);
    chk("R6 valid", 32'(v), 1);
    chk("R6 group", 32'(g), 3);
    chk("R6 source", 32'(s), 4);
    rd(ra(0, 2), d); chk("R6 source flag cleared", 32'(d), 0);
    chk("R6 cpu irq cleared", 32'(cpu_irq), 0);
    // ack still set: second request must wait
    pulse(96'(1) << (2*8+4));
    tick(3);
    chk("R3 blocked while ack set", 32'(cpu_irq), 0);
    rd(ra(0, 2), d); chk("R3 flag pending", 32'(d), 32'h10);
    wr(ra(2, 2), 16'h1);
    tick(1);
    chk("R3 forwards after ack write", 32'(cpu_irq), 1);
    cleanup();
  endtask

  task automatic t_priority();
    logic [15:0] d; logic v; logic [3:0] g; logic [2:0] s;
    wr(ra(1, 1), 16'h06);
    wr(ra(1, 5), 16'h80);
    wr(ra(3, 1), 16'h022);
    pulse((96'(1) << 9) | (96'(1) << 10) | (96'(1) << 47));
    tick(1);
    chk("R5 irq", 32'(cpu_irq), 1);
    do_take(v, g, s);
    chk("R5 first group", 32'(g), 2);
    chk("R5 first source", 32'(s), 1);
    do_take(v, g, s);
    chk("R5 second group", 32'(g), 6);
    chk("R5 second source", 32'(s), 7);
    chk("R5 none left at cpu", 32'(cpu_irq), 0);
    rd(ra(0, 1), d); chk("R5 lower source left", 32'(d), 32'h04);
    wr(ra(2, 1), 16'h1);
    tick(1);
    do_take(v, g, s);
    chk("R5 third group", 32'(g), 2);
    chk("R5 third source", 32'(s), 2);
    cleanup();
  endtask

  task automatic t_mask();
    logic v; logic [3:0] g; logic [2:0] s;
    wr(ra(1, 3), 16'h01);
    wr(ra(3, 1), 16'h008);
    wr(ra(3, 2), 16'h1);
    pulse(96'(1) << 24);
    tick(3);
    chk("R4 masked", 32'(cpu_irq), 0);
    @(negedge clk); take = 1'b1; #1 chk("R6 no vector when masked", 32'(vvalid), 0);
    @(negedge clk); take = 1'b0;
    wr(ra(3, 2), 16'h0);
    chk("R4 unmasked", 32'(cpu_irq), 1);
    wr(ra(3, 1), 16'h000);
    chk("R4 cpu enable off", 32'(cpu_irq), 0);
    wr(ra(3, 1), 16'h008);
    do_take(v, g, s);
    chk("R6 masked source group", 32'(g), 4);
    chk("R6 masked source index", 32'(s), 0);
    cleanup();
  endtask

  task automatic t_soft();
    logic [15:0] d; logic v; logic [3:0] g; logic [2:0] s;
    wr(ra(0, 8), 16'h20);
    @(negedge clk); we = 1'b1; addr = ra(0, 8); wdata = 16'h0; irq[67] = 1'b1;
    @(negedge clk); we = 1'b0; irq[67] = 1'b0;
    rd(ra(0, 8), d); chk("R7 hardware set wins", 32'(d), 32'h08);
    wr(ra(1, 9), 16'h80);
    wr(ra(3, 1), 16'h200);
    wr(ra(0, 9), 16'h80);
    tick(1);
    chk("R7 software irq", 32'(cpu_irq), 1);
    do_take(v, g, s);
    chk("R7 soft group", 32'(g), 10);
    chk("R7 soft source", 32'(s), 7);
    cleanup();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    tick(1);
    t_reset();
    t_regs();
    t_latch();
    t_forward();
    t_priority();
    t_mask();
    t_soft();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule